// File: doc/BRIEF.md
# Free-Running Capture/Compare Timer

A 16-bit up-counter advances once per prescaled clock tick while the timer is enabled and the free-running mode code is selected. It wraps from the all-ones value to zero and flags each wrap with a one-clock pulse. Two channels sit beside the counter. Each one is switched on its own between two roles. As a compare channel it raises a one-clock event when the counter reaches a buffered copy of its register. As a capture channel it latches the counter value into its register when a chosen edge appears on its external input.

Software drives the block through a small write/read register port. It selects the divide ratio and the mode, then picks each channel's role and edges. It loads the compare values and finally sets the run bit. Compare values written while the counter runs only take effect after the next wrap. A capture input is resynchronised before its edges are detected, so the block can take asynchronous pins.

Top module: `frc_timer`

## Requirements
- R1: After reset every readable register (addresses 0 to 5) reads 0000h, and evt_o and ovf_o are low.
- R10: Register map on addr_i: 0 = control (bit 7 run, bits 2:0 divider select), 1 = mode (bits 2:0 mode code, bit 4 channel 0 role, bit 5 channel 1 role), 2 = edge select, 3 = counter (read only), 4 = channel 0 register, 5 = channel 1 register. Unused bits read 0.
- R2: The counter only advances while the run bit is 1 and the mode code is 101b. In every other case it is held at 0000h, and no event or wrap pulse is produced. Clearing the run bit returns the counter to 0000h.
- R3: The counter wraps from FFFFh to 0000h. ovf_o is high for exactly the one cycle in which the counter first reads 0000h after the wrap.
- R4: Divider select value s makes the counter advance once every 2^s clocks (s = 0 to 7). After n clocks of running the counter reads floor(n / 2^s).
- R5: A channel with role bit 0 compares. Its register is copied into a hidden buffer while the timer is stopped. evt_o for that channel is high for one cycle, in the same cycle the counter takes a new value equal to the buffer.
- R6: A write to a compare register while the timer runs does not change the matched value until the next counter wrap, at which point the buffer takes the new value.
- R7: A channel with role bit 1 captures. A selected edge on its cap_i pin, seen three clocks after the pin changes, copies the counter value into its register (readable at its address) and pulses its evt_o for one cycle.
- R8: Edge select uses bits 1:0 for channel 0 and bits 3:2 for channel 1, coded 00 = none, 01 = rising, 10 = falling, 11 = both. An edge that is not selected leaves the register and evt_o unchanged.
- R9: The two channels' roles are independent. One channel can capture while the other compares, and a compare channel's register is never overwritten by its pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for writes and reads |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| cap_i | input | 2 | Capture inputs, one per channel, asynchronous |
| evt_o | output | 2 | Per-channel match or capture pulse |
| ovf_o | output | 1 | Counter wrap pulse |

## Verification
The bench builds the block with its defaults: a 16-bit counter and two channels. At divide-by-1 a full 65536-count wrap fits in the run. That brings the wrap pulse into reach, along with a compare write that only lands after that wrap. At divide-by-128 the counter holds each value for 128 clocks. This makes the value latched by a capture exactly predictable despite the three-clock input path.

// File: rtl/frc_pkg.sv
package frc_pkg;

  // Mode code that selects free-running operation
  localparam logic [2:0] MODE_FREE = 3'b101;

  // Register addresses
  localparam int ADR_CTRL     = 0;
  localparam int ADR_MODE     = 1;
  localparam int ADR_EDGE     = 2;
  localparam int ADR_CNT      = 3;
  localparam int ADR_CCR_BASE = 4;

  // Field positions
  localparam int RUN_BIT      = 7;
  localparam int ROLE_LSB     = 4;
  localparam int SEL_W        = 3;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

endpackage

// File: rtl/frc_prescaler.sv
module frc_prescaler #(
  parameter int SEL_W = 3,
  localparam int DIV_W = (1 << SEL_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask   = ~({DIV_W{1'b1}} << sel_i);
    tick_o = en_i && ((div_q & mask) == mask);
    div_d  = en_i ? div_q + 1'b1 : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

endmodule

// File: rtl/frc_counter.sv
module frc_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         wrap_o,
  output logic         ovf_o
);

  logic [W-1:0] cnt_q;
  logic         ovf_q;

  always_comb begin
    wrap_o = en_i && tick_i && (cnt_q == {W{1'b1}});
    if (!en_i)       cnt_nxt_o = '0;
    else if (tick_i) cnt_nxt_o = cnt_q + 1'b1;
    else             cnt_nxt_o = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt_o;
      ovf_q <= wrap_o;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

endmodule

// File: rtl/frc_channel.sv
module frc_channel
  import frc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         active_i,
  input  logic         tick_i,
  input  logic         wrap_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cnt_nxt_i,
  input  logic         role_i,
  input  edge_sel_e    esel_i,
  input  logic         pin_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ccr_o,
  output logic         evt_o
);

  logic         sync1_q, sync2_q, prev_q;
  logic [W-1:0] ccr_q, ccr_d;
  logic [W-1:0] buf_q, buf_d;
  logic         evt_q, evt_d;
  logic         rise, fall, hit, cap, match;

  always_comb begin
    rise = sync2_q & ~prev_q;
    fall = ~sync2_q & prev_q;
    unique case (esel_i)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
    cap   = active_i && role_i && hit;
    match = active_i && !role_i && tick_i && (cnt_nxt_i == buf_q);

    if (cap)       ccr_d = cnt_i;
    else if (wr_i) ccr_d = wdata_i;
    else           ccr_d = ccr_q;

    buf_d = (!active_i || wrap_i) ? ccr_q : buf_q;
    evt_d = cap | match;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      ccr_q   <= '0;
      buf_q   <= '0;
      evt_q   <= 1'b0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      ccr_q   <= ccr_d;
      buf_q   <= buf_d;
      evt_q   <= evt_d;
    end
  end

  assign ccr_o = ccr_q;
  assign evt_o = evt_q;

endmodule

// File: rtl/frc_timer.sv
module frc_timer
  import frc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = 2,
  localparam int AW   = $clog2(ADR_CCR_BASE + NCH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic [NCH-1:0]   cap_i,
  output logic [NCH-1:0]   evt_o,
  output logic             ovf_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // configuration registers
  logic             run_q, run_d;
  logic [SEL_W-1:0] csel_q, csel_d;
  logic [2:0]       mode_q, mode_d;
  logic [NCH-1:0]   role_q, role_d;
  logic [2*NCH-1:0] esel_q, esel_d;
  logic             wr_ctrl, wr_mode, wr_edge;
  logic             active;

  always_comb begin
    wr_ctrl = wr_en_i && (addr_i == AW'(ADR_CTRL));
    wr_mode = wr_en_i && (addr_i == AW'(ADR_MODE));
    wr_edge = wr_en_i && (addr_i == AW'(ADR_EDGE));
    run_d   = wr_ctrl ? wdata_i[RUN_BIT]            : run_q;
    csel_d  = wr_ctrl ? wdata_i[SEL_W-1:0]          : csel_q;
    mode_d  = wr_mode ? wdata_i[2:0]                : mode_q;
    role_d  = wr_mode ? wdata_i[ROLE_LSB +: NCH]    : role_q;
    esel_d  = wr_edge ? wdata_i[2*NCH-1:0]          : esel_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      csel_q <= '0;
      mode_q <= '0;
      role_q <= '0;
      esel_q <= '0;
    end else begin
      run_q  <= run_d;
      csel_q <= csel_d;
      mode_q <= mode_d;
      role_q <= role_d;
      esel_q <= esel_d;
    end
  end

  assign active = run_q && (mode_q == MODE_FREE);

  // count path
  logic             tick, wrap;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  frc_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .en_i   (active),
    .sel_i  (csel_q),
    .tick_o (tick)
  );

  frc_counter #(.W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .en_i      (active),
    .tick_i    (tick),
    .cnt_o     (cnt_q),
    .cnt_nxt_o (cnt_nxt),
    .wrap_o    (wrap),
    .ovf_o     (ovf_o)
  );

  // channels
  logic [CNT_W-1:0] ccr [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wr_c;
    assign wr_c = wr_en_i && (addr_i == AW'(ADR_CCR_BASE + c));

    frc_channel #(.W(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .active_i  (active),
      .tick_i    (tick),
      .wrap_i    (wrap),
      .cnt_i     (cnt_q),
      .cnt_nxt_i (cnt_nxt),
      .role_i    (role_q[c]),
      .esel_i    (edge_sel_e'(esel_q[2*c +: 2])),
      .pin_i     (cap_i[c]),
      .wr_i      (wr_c),
      .wdata_i   (wdata_i),
      .ccr_o     (ccr[c]),
      .evt_o     (evt_o[c])
    );
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(ADR_CTRL)) begin
      rdata_o[RUN_BIT]     = run_q;
      rdata_o[SEL_W-1:0]   = csel_q;
    end else if (addr_i == AW'(ADR_MODE)) begin
      rdata_o[2:0]             = mode_q;
      rdata_o[ROLE_LSB +: NCH] = role_q;
    end else if (addr_i == AW'(ADR_EDGE)) begin
      rdata_o[2*NCH-1:0] = esel_q;
    end else if (addr_i == AW'(ADR_CNT)) begin
      rdata_o = cnt_q;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (addr_i == AW'(ADR_CCR_BASE + i)) rdata_o = ccr[i];
      end
    end
  end

endmodule

// File: rtl/frc_timer_chk.sv
module frc_timer_chk #(
  parameter int W   = 16,
  parameter int NCH = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           active_i,
  input logic [W-1:0]   cnt_i,
  input logic           ovf_i,
  input logic [NCH-1:0] evt_i,
  input logic [NCH-1:0] role_i
);

  // R2: a stopped timer holds zero on the following cycle
  p_stop_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (cnt_i == '0));

  // R2: no pulses out of a stopped timer
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> ((evt_i == '0) && !ovf_i));

  // R4: a running counter only ever steps by one
  p_step_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(cnt_i) && $past(active_i)) |-> (cnt_i == W'($past(cnt_i) + 1'b1)));

  // R3: the wrap pulse coincides with a zero count
  p_ovf_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |-> (cnt_i == '0));

  // R3: the wrap pulse lasts one cycle
  p_ovf_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> !ovf_i);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R5: a compare event lasts one cycle
    p_cmp_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i[c] && !role_i[c]) |=> !evt_i[c]);

    // R7: events only follow a running cycle
    p_evt_running_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[c] |-> $past(active_i));
  end

endmodule

bind frc_timer frc_timer_chk #(.W(CNT_W), .NCH(NCH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_n),
  .active_i (active),
  .cnt_i    (cnt_q),
  .ovf_i    (ovf_o),
  .evt_i    (evt_o),
  .role_i   (role_q)
);

// File: tb/tb_frc_timer.sv
`timescale 1ns/1ps
module tb_frc_timer;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = 3'd3;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [1:0]  cap_i = 2'b00;
  logic [1:0]  evt_o;
  logic        ovf_o;

  int checks = 0;
  int fails  = 0;
  int since_en = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  frc_timer dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .cap_i   (cap_i),
    .evt_o   (evt_o),
    .ovf_o   (ovf_o)
  );

  // {address, write data, expected readback}
  localparam int NV = 7;
  localparam logic [34:0] VECS [NV] = '{
    {3'd0, 16'h007F, 16'h0007},
    {3'd1, 16'hFFFF, 16'h0037},
    {3'd2, 16'hFFFF, 16'h000F},
    {3'd4, 16'h1234, 16'h1234},
    {3'd5, 16'hBEEF, 16'hBEEF},
    {3'd3, 16'h5555, 16'h0000},
    {3'd0, 16'h0005, 16'h0005}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk_i);
    since_en += k;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = 3'd3;
    since_en++;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
    addr_i = 3'd3;
  endtask

  task automatic align();
    while ((since_en % 128) != 0) step(1);
  endtask

  task automatic start(input logic [15:0] ctrl);
    wr(3'd0, ctrl);
    since_en = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reset register", v, 16'h0000);
    end
    chk("R1 evt after reset", {14'b0, evt_o}, 16'h0000);
    chk("R1 ovf after reset", {15'b0, ovf_o}, 16'h0000);

    // R10: register map via vector table
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i][34:32], VECS[i][31:16]);
      rd(VECS[i][34:32], v);
      chk("R10 readback", v, VECS[i][15:0]);
    end
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0000); wr(3'd2, 16'h0000);

    // R2: run bit set but mode code not free-running
    wr(3'd1, 16'h0004);
    start(16'h0080);
    step(20);
    rd(3'd3, v); chk("R2 wrong mode holds zero", v, 16'h0000);
    wr(3'd0, 16'h0000);

    // R4: divide by 4 and by 128
    wr(3'd1, 16'h0005);
    start(16'h0082);
    step(40);
    rd(3'd3, v); chk("R4 divide by 4", v, 16'd10);
    step(3);
    rd(3'd3, v); chk("R4 divide by 4 hold", v, 16'd10);
    wr(3'd0, 16'h0000);
    step(1);
    rd(3'd3, v); chk("R2 stop clears", v, 16'h0000);
    start(16'h0087);
    step(256);
    rd(3'd3, v); chk("R4 divide by 128", v, 16'd2);
    wr(3'd0, 16'h0000);

    // R5, R6, R3: compare and wrap at divide by 1
    wr(3'd4, 16'd100);
    start(16'h0080);
    step(100);
    rd(3'd3, v); chk("R5 count at match", v, 16'd100);
    chk("R5 match pulse", {15'b0, evt_o[0]}, 16'h0001);
    step(1);
    chk("R5 match one cycle", {15'b0, evt_o[0]}, 16'h0000);
    wr(3'd4, 16'd200);
    step(200 - since_en);
    rd(3'd3, v); chk("R6 count 200", v, 16'd200);
    chk("R6 no match before wrap", {15'b0, evt_o[0]}, 16'h0000);
    step(65535 - since_en);
    rd(3'd3, v); chk("R3 count max", v, 16'hFFFF);
    chk("R3 no ovf before wrap", {15'b0, ovf_o}, 16'h0000);
    step(1);
    rd(3'd3, v); chk("R3 wrapped to zero", v, 16'h0000);
    chk("R3 ovf pulse", {15'b0, ovf_o}, 16'h0001);
    step(1);
    chk("R3 ovf one cycle", {15'b0, ovf_o}, 16'h0000);
    step(199);
    rd(3'd3, v); chk("R6 count 200 after wrap", v, 16'd200);
    chk("R6 new value matches after wrap", {15'b0, evt_o[0]}, 16'h0001);
    wr(3'd0, 16'h0000);

    // R7, R8, R9: ch1 captures rising, ch0 compares an unreached value
    wr(3'd4, 16'h8000);
    wr(3'd1, 16'h0025);
    wr(3'd2, 16'h0004);
    start(16'h0087);
    step(3 * 128);
    cap_i[1] = 1'b1;
    step(3);
    chk("R7 capture pulse", {15'b0, evt_o[1]}, 16'h0001);
    rd(3'd5, v); chk("R7 captured count", v, 16'd3);
    rd(3'd4, v); chk("R9 compare register untouched", v, 16'h8000);
    step(1);
    chk("R7 capture one cycle", {15'b0, evt_o[1]}, 16'h0000);
    align();
    cap_i[1] = 1'b0;
    step(3);
    chk("R8 falling ignored under rising", {15'b0, evt_o[1]}, 16'h0000);
    rd(3'd5, v); chk("R8 register kept", v, 16'd3);

    wr(3'd2, 16'h000C);
    align();
    cap_i[1] = 1'b1;
    step(3);
    chk("R8 both: rising pulse", {15'b0, evt_o[1]}, 16'h0001);
    rd(3'd5, v); chk("R8 both: rising value", v, 16'((since_en - 3) >> 7));
    align();
    cap_i[1] = 1'b0;
    step(3);
    chk("R8 both: falling pulse", {15'b0, evt_o[1]}, 16'h0001);
    rd(3'd5, v); chk("R8 both: falling value", v, 16'((since_en - 3) >> 7));

    // ch0 capture on falling only
    wr(3'd1, 16'h0035);
    wr(3'd2, 16'h000E);
    align();
    cap_i[0] = 1'b1;
    step(3);
    chk("R8 ch0 rising ignored", {15'b0, evt_o[0]}, 16'h0000);
    rd(3'd4, v); chk("R8 ch0 register kept", v, 16'h8000);
    align();
    cap_i[0] = 1'b0;
    step(3);
    chk("R9 ch0 falling pulse", {15'b0, evt_o[0]}, 16'h0001);
    rd(3'd4, v); chk("R9 ch0 captured", v, 16'((since_en - 3) >> 7));

    // ch0 edge select none
    wr(3'd2, 16'h000C);
    rd(3'd4, v);
    begin
      logic [15:0] keep;
      keep = v;
      align();
      cap_i[0] = 1'b1;
      step(3);
      chk("R8 none: rising ignored", {15'b0, evt_o[0]}, 16'h0000);
      align();
      cap_i[0] = 1'b0;
      step(3);
      chk("R8 none: falling ignored", {15'b0, evt_o[0]}, 16'h0000);
      rd(3'd4, v); chk("R8 none: register kept", v, keep);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule